// File: doc/BRIEF.md
# Programmable RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB display panel. From a single source clock it derives a pixel-rate tick through an integer divider. It then runs a horizontal pixel counter and a vertical line counter through four phases in a fixed order: sync pulse, back porch, active region and front porch. From those counters it drives horizontal sync, vertical sync, data enable and a pixel clock, and it reports the active column and row to the pixel source downstream.

Every timing length comes in on a plain parallel configuration input and is written as the count minus one. Each output has its own polarity bit, and the pixel clock has a bit that selects its edge. A divider change can take effect at once or be held until the next frame boundary. There are two run controls: one stops the raster at once, and one lets the current frame finish first. A frame event can be placed at the start of any one of the four vertical phases. It sets a sticky pending flag, and that flag drives the interrupt line when both interrupt enables are set.

Top module: `lcd_tgen`

## Requirements
- R1: Each line starts on the first pixel tick after the counters leave the origin. Horizontal sync is active for `hsw_i`+1 ticks, followed by `hbp_i`+1 back-porch ticks, `hact_i`+1 active ticks and `hfp_i`+1 front-porch ticks, so a line lasts `hsw_i+hbp_i+hact_i+hfp_i+4` ticks.
- R2: Vertical sync is active for `vsw_i`+1 lines at the start of a frame, followed by `vbp_i`+1, `vact_i`+1 and `vfp_i`+1 lines. The vertical counter advances only at the end of a line.
- R3: Data enable is active only while both counters are in their active phases. `col_o` and `row_o` then give the zero-based active pixel and line, and both are zero at every other time.
- R4: When an invert bit is 0, its sync or enable output is high while active. When the bit is 1, the output is low while active. While the raster is stopped, each output rests at its inactive level, which is the value of its invert bit. `pclk_o` rests at `pclk_edge_i`.
- R5: `pix_tick_o` pulses once every `clkval_i`+1 source cycles, in the last cycle of each pixel. Within pixel cycle d, the raw clock is high when d > `clkval_i`/2 (integer division). `pclk_o` is the raw clock XOR `pclk_edge_i`.
- R6: With `clk_upd_frame_i`=0, a new `clkval_i` takes effect on the next source cycle. With `clk_upd_frame_i`=1 and the raster running, the old divisor holds until the end of the current frame.
- R7: Lowering `en_now_i` stops the raster on the next cycle. The next start begins at the frame origin.
- R8: Lowering `en_frame_i` while running lets the current frame complete, and the raster then stops at the frame boundary. Starting the raster requires both enables to be high.
- R9: `irq_pos_i` places the frame event on the first pixel of the first line of a vertical phase: 0 = back porch, 1 = sync, 2 = active, 3 = front porch. The pending flag is first seen one pixel after that pixel starts.
- R10: The pending flag stays set until a cycle with `irq_clr_i`=1 clears it.
- R11: `irq_o` is high only while the pending flag, `irq_gen_en_i` and `irq_frame_en_i` are all set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_now_i | input | 1 | Immediate run enable |
| en_frame_i | input | 1 | Per-frame run enable |
| hsw_i | input | 8 | Horizontal sync width minus one |
| hbp_i | input | 8 | Horizontal back porch minus one |
| hact_i | input | 11 | Active width minus one |
| hfp_i | input | 8 | Horizontal front porch minus one |
| vsw_i | input | 8 | Vertical sync width minus one |
| vbp_i | input | 8 | Vertical back porch minus one |
| vact_i | input | 11 | Active height minus one |
| vfp_i | input | 8 | Vertical front porch minus one |
| inv_hs_i | input | 1 | Horizontal sync invert |
| inv_vs_i | input | 1 | Vertical sync invert |
| inv_den_i | input | 1 | Data enable invert |
| pclk_edge_i | input | 1 | Pixel clock edge select |
| clkval_i | input | 8 | Divider value, divisor minus one |
| clk_upd_frame_i | input | 1 | Apply divider changes only at frame end |
| irq_pos_i | input | 2 | Frame event phase select |
| irq_gen_en_i | input | 1 | Global interrupt enable |
| irq_frame_en_i | input | 1 | Frame interrupt enable |
| irq_clr_i | input | 1 | Clear pending flag |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| den_o | output | 1 | Data enable |
| pclk_o | output | 1 | Pixel clock |
| pix_tick_o | output | 1 | Pixel advance pulse |
| col_o | output | 11 | Active column |
| row_o | output | 11 | Active row |
| irq_pend_o | output | 1 | Frame event pending |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a divider change made in the middle of a frame while frame-boundary updates are selected. The old and new divisors are only told apart by counting pixel ticks on both sides of the frame boundary. The stimulus therefore starts the raster at a divisor of one and changes the divider a few cycles in. It counts ticks over a fixed window inside the frame and over a second window just after the frame wraps, and compares those counts with the ones seen when immediate update is selected. Every timing sweep starts from the stopped state, and the bench checks every source cycle over two frames against an arithmetic position model (column, line, pixel phase) for several porch, size, polarity and divider combinations.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
    // raster phases in the order they occur on each axis
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } tg_phase_e;
endpackage

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis
    import lcd_tgen_pkg::*;
#(
    parameter int PORCH_W = 8,
    parameter int SIZE_W  = 11,
    localparam int CNT_W  = (SIZE_W > PORCH_W) ? SIZE_W : PORCH_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               hold_i,
    input  logic               step_i,
    input  logic [PORCH_W-1:0] sync_len_i,
    input  logic [PORCH_W-1:0] back_len_i,
    input  logic [SIZE_W-1:0]  act_len_i,
    input  logic [PORCH_W-1:0] front_len_i,
    output tg_phase_e          phase_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               wrap_o
);
    typedef struct packed {
        tg_phase_e        phase;
        logic [CNT_W-1:0] cnt;
    } axis_st_t;

    axis_st_t         st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic             last;

    always_comb begin
        unique case (st_q.phase)
            PH_SYNC:  lim = CNT_W'(sync_len_i);
            PH_BACK:  lim = CNT_W'(back_len_i);
            PH_ACT:   lim = CNT_W'(act_len_i);
            default:  lim = CNT_W'(front_len_i);
        endcase
        last   = (st_q.cnt == lim);
        wrap_o = step_i && !hold_i && last && (st_q.phase == PH_FRONT);

        st_d = st_q;
        if (hold_i) begin
            st_d = '{phase: PH_SYNC, cnt: '0};
        end else if (step_i) begin
            if (last) begin
                st_d.cnt   = '0;
                st_d.phase = tg_phase_e'(st_q.phase + 2'd1);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_SYNC, cnt: '0};
        else         st_q <= st_d;
    end

    assign phase_o = st_q.phase;
    assign cnt_o   = st_q.cnt;

    // R1 R2
    wrap_to_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (phase_o == PH_SYNC && cnt_o == '0));
endmodule

// File: rtl/lcd_tgen_clkdiv.sv
module lcd_tgen_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] clkval_i,
    input  logic             upd_frame_i,
    input  logic             frame_end_i,
    output logic             tick_o,
    output logic             pclk_raw_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] lim;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    load;

    always_comb begin
        tick_o     = run_i && (st_q.div >= st_q.lim);
        pclk_raw_o = run_i && (st_q.div > (st_q.lim >> 1));
        load       = !upd_frame_i || !run_i || frame_end_i;

        st_d     = st_q;
        st_d.lim = load ? clkval_i : st_q.lim;
        st_d.div = (!run_i || tick_o) ? '0 : st_q.div + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5
    tick_restarts_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (st_q.div == '0));

    // R6
    frame_hold_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && upd_frame_i && !frame_end_i) |=> $stable(st_q.lim));
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
    import lcd_tgen_pkg::*;
#(
    parameter int PORCH_W = 8,
    parameter int SIZE_W  = 11,
    parameter int DIV_W   = 8,
    localparam int CNT_W  = (SIZE_W > PORCH_W) ? SIZE_W : PORCH_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_now_i,
    input  logic               en_frame_i,
    input  logic [PORCH_W-1:0] hsw_i,
    input  logic [PORCH_W-1:0] hbp_i,
    input  logic [SIZE_W-1:0]  hact_i,
    input  logic [PORCH_W-1:0] hfp_i,
    input  logic [PORCH_W-1:0] vsw_i,
    input  logic [PORCH_W-1:0] vbp_i,
    input  logic [SIZE_W-1:0]  vact_i,
    input  logic [PORCH_W-1:0] vfp_i,
    input  logic               inv_hs_i,
    input  logic               inv_vs_i,
    input  logic               inv_den_i,
    input  logic               pclk_edge_i,
    input  logic [DIV_W-1:0]   clkval_i,
    input  logic               clk_upd_frame_i,
    input  logic [1:0]         irq_pos_i,
    input  logic               irq_gen_en_i,
    input  logic               irq_frame_en_i,
    input  logic               irq_clr_i,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               den_o,
    output logic               pclk_o,
    output logic               pix_tick_o,
    output logic [SIZE_W-1:0]  col_o,
    output logic [SIZE_W-1:0]  row_o,
    output logic               irq_pend_o,
    output logic               irq_o
);
    typedef struct packed {
        logic run;
        logic pend;
    } top_st_t;

    top_st_t    st_d, st_q;
    logic       tick, pclk_raw, frame_end, h_wrap, den_act, frame_evt;
    tg_phase_e  h_phase, v_phase, evt_phase;
    logic [CNT_W-1:0] h_cnt, v_cnt;

    lcd_tgen_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (st_q.run),
        .clkval_i    (clkval_i),
        .upd_frame_i (clk_upd_frame_i),
        .frame_end_i (frame_end),
        .tick_o      (tick),
        .pclk_raw_o  (pclk_raw)
    );

    lcd_tgen_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W)) i_hax (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hold_i      (!st_q.run),
        .step_i      (tick),
        .sync_len_i  (hsw_i),
        .back_len_i  (hbp_i),
        .act_len_i   (hact_i),
        .front_len_i (hfp_i),
        .phase_o     (h_phase),
        .cnt_o       (h_cnt),
        .wrap_o      (h_wrap)
    );

    lcd_tgen_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W)) i_vax (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hold_i      (!st_q.run),
        .step_i      (h_wrap),
        .sync_len_i  (vsw_i),
        .back_len_i  (vbp_i),
        .act_len_i   (vact_i),
        .front_len_i (vfp_i),
        .phase_o     (v_phase),
        .cnt_o       (v_cnt),
        .wrap_o      (frame_end)
    );

    always_comb begin
        unique case (irq_pos_i)
            2'd0:    evt_phase = PH_BACK;
            2'd1:    evt_phase = PH_SYNC;
            2'd2:    evt_phase = PH_ACT;
            default: evt_phase = PH_FRONT;
        endcase
        frame_evt = tick && (h_phase == PH_SYNC) && (h_cnt == '0)
                 && (v_phase == evt_phase) && (v_cnt == '0);

        st_d      = st_q;
        st_d.run  = en_now_i && (en_frame_i || (st_q.run && !frame_end));
        st_d.pend = frame_evt || (st_q.pend && !irq_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign den_act    = st_q.run && (h_phase == PH_ACT) && (v_phase == PH_ACT);
    assign hsync_o    = (st_q.run && h_phase == PH_SYNC) ^ inv_hs_i;
    assign vsync_o    = (st_q.run && v_phase == PH_SYNC) ^ inv_vs_i;
    assign den_o      = den_act ^ inv_den_i;
    assign pclk_o     = pclk_raw ^ pclk_edge_i;
    assign pix_tick_o = tick;
    assign col_o      = den_act ? h_cnt[SIZE_W-1:0] : '0;
    assign row_o      = den_act ? v_cnt[SIZE_W-1:0] : '0;
    assign irq_pend_o = st_q.pend;
    assign irq_o      = st_q.pend && irq_gen_en_i && irq_frame_en_i;

    // R3
    den_in_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (den_o != inv_den_i) |-> (hsync_o == inv_hs_i && vsync_o == inv_vs_i));

    // R7
    stop_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_now_i |=> (col_o == '0 && row_o == '0 && !pix_tick_o));

    // R8
    frame_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && en_now_i && !frame_end) |=> st_q.run);

    // R10
    pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pend_o && !irq_clr_i) |=> irq_pend_o);
endmodule

// File: tb/test_lcd_tgen.sv
module test_lcd_tgen;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, en_now, en_frame;
    logic [7:0]  hsw, hbp, hfp, vsw, vbp, vfp, clkval;
    logic [10:0] hact, vact;
    logic        inv_hs, inv_vs, inv_den, edge_sel, upd_frame;
    logic [1:0]  irq_pos;
    logic        gie, fie, clr;
    logic        hsync, vsync, den, pclk, tick, pend, irq;
    logic [10:0] col, row;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    lcd_tgen i_lcd_tgen (
        .clk_i(clk), .rst_ni(rst_n), .en_now_i(en_now), .en_frame_i(en_frame),
        .hsw_i(hsw), .hbp_i(hbp), .hact_i(hact), .hfp_i(hfp),
        .vsw_i(vsw), .vbp_i(vbp), .vact_i(vact), .vfp_i(vfp),
        .inv_hs_i(inv_hs), .inv_vs_i(inv_vs), .inv_den_i(inv_den),
        .pclk_edge_i(edge_sel), .clkval_i(clkval), .clk_upd_frame_i(upd_frame),
        .irq_pos_i(irq_pos), .irq_gen_en_i(gie), .irq_frame_en_i(fie),
        .irq_clr_i(clr), .hsync_o(hsync), .vsync_o(vsync), .den_o(den),
        .pclk_o(pclk), .pix_tick_o(tick), .col_o(col), .row_o(row),
        .irq_pend_o(pend), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int htot();
        return int'(hsw) + int'(hbp) + int'(hact) + int'(hfp) + 4;
    endfunction

    function automatic int vtot();
        return int'(vsw) + int'(vbp) + int'(vact) + int'(vfp) + 4;
    endfunction

    task automatic stop_run();
        @(negedge clk);
        en_now = 1'b0;
        en_frame = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // after this returns, the next negedge is source cycle k=0 of the frame
    task automatic start_run();
        @(negedge clk);
        en_now = 1'b1;
        en_frame = 1'b1;
        @(posedge clk);
    endtask

    task automatic set_default();
        hsw = 8'd1; hbp = 8'd1; hact = 11'd3; hfp = 8'd0;
        vsw = 8'd0; vbp = 8'd1; vact = 11'd2; vfp = 8'd0;
        inv_hs = 0; inv_vs = 0; inv_den = 0; edge_sel = 0;
        clkval = 8'd0; upd_frame = 0;
    endtask

    // R1 R2 R3 R5: two whole frames compared against an arithmetic raster model
    task automatic sweep(input string tag);
        int n, ht, vt, total, p, d, x, y, hs0, vs0;
        bit in_h, in_v, de;
        bit bh, bv, bd, bp;
        int ah, eh, av, ev, ad, ed, ap, ep, a3, e3, a5, e5;
        n = int'(clkval) + 1; ht = htot(); vt = vtot();
        total = 2 * ht * vt * n;
        hs0 = int'(hsw) + int'(hbp) + 2;
        vs0 = int'(vsw) + int'(vbp) + 2;
        bh = 0; bv = 0; bd = 0; bp = 0;
        ah = 0; eh = 0; av = 0; ev = 0; ad = 0; ed = 0; ap = 0; ep = 0;
        start_run();
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            p = k / n; d = k % n;
            x = p % ht; y = (p / ht) % vt;
            in_h = (x >= hs0) && (x <= hs0 + int'(hact));
            in_v = (y >= vs0) && (y <= vs0 + int'(vact));
            de = in_h && in_v;
            if (!bh && (hsync !== ((x <= int'(hsw)) ^ inv_hs))) begin
                bh = 1; ah = int'(hsync); eh = int'((x <= int'(hsw)) ^ inv_hs);
            end
            if (!bv && (vsync !== ((y <= int'(vsw)) ^ inv_vs))) begin
                bv = 1; av = int'(vsync); ev = int'((y <= int'(vsw)) ^ inv_vs);
            end
            a3 = int'({den, col, row});
            e3 = ((de ^ inv_den) ? 1 << 22 : 0)
               + (de ? ((x - hs0) << 11) + (y - vs0) : 0);
            if (!bd && (a3 != e3)) begin bd = 1; ad = a3; ed = e3; end
            a5 = int'({pclk, tick});
            e5 = (int'((d > (n - 1) / 2) ^ edge_sel) << 1) + int'(d == n - 1);
            if (!bp && (a5 != e5)) begin bp = 1; ap = a5; ep = e5; end
        end
        chk(!bh, {"R1 hsync ", tag}, ah, eh);
        chk(!bv, {"R2 vsync ", tag}, av, ev);
        chk(!bd, {"R3 den/col/row ", tag}, ad, ed);
        chk(!bp, {"R5 pclk/tick ", tag}, ap, ep);
        stop_run();
    endtask

    task automatic irq_test(input logic [1:0] sel, input int line, input string req);
        int n, first, lim;
        irq_pos = sel;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(pend == 1'b0, "R10 cleared by pulse", int'(pend), 0);
        n = int'(clkval) + 1;
        lim = htot() * vtot() * n;
        first = -1;
        start_run();
        for (int k = 0; k < lim; k++) begin
            @(negedge clk);
            if (first < 0 && pend) first = k;
        end
        chk(first == (line * htot() + 1) * n, req, first, (line * htot() + 1) * n);
        chk(pend == 1'b1, "R10 pending stays set", int'(pend), 1);
        chk(irq == 1'b1, "R11 irq with both enables", int'(irq), 1);
        stop_run();
    endtask

    initial begin
        int f, cnt, c1, c2;
        rst_n = 0; en_now = 0; en_frame = 0;
        irq_pos = 2'd1; gie = 1; fie = 1; clr = 0;
        set_default();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({hsync, vsync, den, pclk, tick} == 5'b0, "R4 reset idle levels",
            int'({hsync, vsync, den, pclk, tick}), 0);
        chk(pend == 0 && irq == 0 && col == 0 && row == 0, "R10 reset clear",
            int'({pend, irq}), 0);

        // R4 idle levels follow invert bits while stopped
        inv_hs = 1; inv_vs = 1; inv_den = 1; edge_sel = 1;
        @(negedge clk);
        chk({hsync, vsync, den, pclk} == 4'hF, "R4 inverted idle",
            int'({hsync, vsync, den, pclk}), 15);

        set_default();
        sweep("cfg0 div1");
        set_default(); clkval = 8'd1; inv_hs = 1; inv_den = 1; edge_sel = 1;
        sweep("cfg1 R4 inverted div2");
        set_default();
        hsw = 0; hbp = 0; hact = 0; hfp = 0; vsw = 0; vbp = 0; vact = 0; vfp = 0;
        clkval = 8'd2; inv_vs = 1;
        sweep("cfg2 minimal div3");
        set_default();
        hsw = 2; hbp = 0; hact = 5; hfp = 2; vsw = 1; vbp = 0; vact = 3; vfp = 1;
        clkval = 8'd3;
        sweep("cfg3 wide div4");

        // R7: immediate stop from inside the active region, then restart at origin
        set_default(); clkval = 8'd1;
        start_run();
        for (int k = 0; k <= (3 * htot() + 4) * 2; k++) @(negedge clk);
        chk(den == 1'b1 && col == 0 && row == 0, "R7 active before stop",
            int'({den, col}), 1 << 11);
        en_now = 1'b0;
        @(negedge clk);
        chk(den == 1'b0 && hsync == 1'b0 && col == 0 && tick == 0, "R7 stopped next cycle",
            int'({den, hsync, tick}), 0);
        sweep("R7 restart from origin");

        // R8: clearing the per-frame enable finishes the frame
        set_default();
        f = htot() * vtot();
        cnt = 0;
        start_run();
        for (int k = 0; k < 2 * f; k++) begin
            @(negedge clk);
            if (k == 1) en_frame = 1'b0;
            if (k == htot()) chk(hsync == 1'b1, "R8 still running mid frame", int'(hsync), 1);
            if (k == f) chk(hsync == 1'b0, "R8 stopped at frame end", int'(hsync), 0);
            if (k >= f && den) cnt++;
        end
        chk(cnt == 0, "R8 no output after frame end", cnt, 0);
        stop_run();

        // R6: divider change held to frame end
        set_default(); upd_frame = 1;
        f = htot() * vtot();
        c1 = 0; c2 = 0;
        start_run();
        for (int k = 0; k < f + 30; k++) begin
            @(negedge clk);
            if (k >= 6 && k <= 35) c1 += int'(tick);
            if (k >= f) c2 += int'(tick);
            if (k == 5) clkval = 8'd2;
        end
        chk(c1 == 30, "R6 old divisor kept within frame", c1, 30);
        chk(c2 == 10, "R6 new divisor after frame end", c2, 10);
        stop_run();

        // R6: immediate divider change
        set_default(); upd_frame = 0;
        c1 = 0;
        start_run();
        for (int k = 0; k < 36; k++) begin
            @(negedge clk);
            if (k >= 6) c1 += int'(tick);
            if (k == 5) clkval = 8'd2;
        end
        chk(c1 == 10, "R6 immediate divisor change", c1, 10);
        stop_run();

        // R9: event phase select (lines: sync 0, back 1, active 3, front 6)
        set_default(); clkval = 8'd1;
        irq_test(2'd1, 0, "R9 event at sync");
        irq_test(2'd0, 1, "R9 event at back porch");
        irq_test(2'd2, 3, "R9 event at active");
        irq_test(2'd3, 6, "R9 event at front porch");

        // R11: gating by both enables, pending still set from last event
        @(negedge clk); gie = 0;
        @(negedge clk);
        chk(irq == 1'b0 && pend == 1'b1, "R11 global enable off", int'(irq), 0);
        gie = 1; fie = 0;
        @(negedge clk);
        chk(irq == 1'b0, "R11 frame enable off", int'(irq), 0);
        fie = 1;
        @(negedge clk);
        chk(irq == 1'b1, "R11 both enables on", int'(irq), 1);
        clr = 1;
        @(negedge clk); clr = 0;
        chk(pend == 1'b0 && irq == 1'b0, "R10 clear drops irq", int'({pend, irq}), 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule